// File: doc/BRIEF.md
# Triple-Redundant Serial Shift Register with Mismatch Flag

The block is a serial shift register whose every stage keeps its bit in three separate flip-flops. All three copies of a stage load the same incoming bit on each rising clock edge. A two-of-three vote over the copies forms the stage's value. That value drives the next stage, and from the last stage it drives the serial output. A stage whose copies do not all agree raises a local mismatch. The mismatches of all stages are OR-combined into one live error output that sits beside the serial output.

An active-low asynchronous clear forces every copy to 0, and an active-low asynchronous preset forces every copy to 1. Clear wins when both are asserted. The parameter `CTRL_BUF` chooses how these two controls reach the copies. When it is 1, each stage receives them through its own buffered net followed by an inverter, so one disturbance on that net reaches all three copies of the stage together. When it is 0, the controls are inverted and driven straight to the copies. For verification, a flip input per copy captures the inverted value into that one copy on the next edge.

Top module: `tmr_shift_reg`

## Requirements
- R1: With no flip requested, all three copies of every stage capture the same bit on each edge, so `err_o` stays 0 during normal shifting.
- R2: A single flipped copy in a stage (`flip_i[3*s+c]`, where s is the stage and c the copy in 0..2) leaves that stage's voted value unchanged, so `dout_o` is unaffected.
- R3: After an edge at which any copy was flipped, `err_o` is 1. The flag is the OR of the per-stage mismatches of all stages.
- R4: `err_o` returns to 0 after the next edge with no flip, because the voted value is rewritten into all copies.
- R5: Two flipped copies in the same stage invert that stage's voted value. For the last stage, `dout_o` is inverted right after that edge.
- R6: Once the register is full, `dout_o` after edge n equals the `din_i` value captured at edge n-LEN+1. This holds for an all-zeros stream and for an alternating stream.
- R7: While `rst_ni` is 0, every copy is 0 asynchronously: `dout_o` is 0 and `err_o` is 0.
- R8: While `set_ni` is 0 and `rst_ni` is 1, every copy is 1: `dout_o` is 1 and `err_o` is 0.
- R9: Clear has priority. With both `rst_ni` and `set_ni` at 0, `dout_o` is 0.
- R10: `CTRL_BUF=0` and `CTRL_BUF=1` give identical shifting, clear and preset behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock of all copies |
| rst_ni | input | 1 | Asynchronous clear, active low |
| set_ni | input | 1 | Asynchronous preset, active low |
| din_i | input | 1 | Serial data in |
| flip_i | input | 3*LEN | Per-copy fault flip, bit 3*s+c |
| dout_o | output | 1 | Voted value of the last stage |
| err_o | output | 1 | OR of all stage mismatches |

## Verification
The bench builds two instances. `dut_i` uses the full length of 100 with the buffered control path, which exposes the 100-cycle latency and single and double flips at the first, middle and last stages. A second instance uses length 4 with direct controls, fed by the same serial stream, so the unbuffered variant is compared on the same shifting, clear and preset behaviour. Both instances share clear and preset, which is what allows R10 to be checked.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  function automatic logic vote3(input logic [2:0] c);
    return (c[0] & c[1]) | (c[0] & c[2]) | (c[1] & c[2]);
  endfunction

  function automatic logic mismatch3(input logic [2:0] c);
    return (c[0] ^ c[1]) | (c[0] ^ c[2]);
  endfunction
endpackage

// File: rtl/tmr_copy_ff.sv
module tmr_copy_ff (
  input  logic clk_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic d_i,
  input  logic flip_i,
  output logic q_o
);
  // clear dominates preset
  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i ^ flip_i;
  end
endmodule

// File: rtl/tmr_stage.sv
module tmr_stage #(
  parameter int unsigned NCOPY    = 3,
  parameter bit          CTRL_BUF = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_ni,
  input  logic             d_i,
  input  logic [NCOPY-1:0] flip_i,
  output logic             vote_o,
  output logic             miss_o
);
  import tmr_pkg::*;

  logic clr, set;
  logic [NCOPY-1:0] cp;

  generate
    if (CTRL_BUF) begin : g_buf
      // dedicated buffered net per stage, then inverter, shared by all copies
      logic clr_buf, set_buf;
      assign clr_buf = rst_ni;
      assign set_buf = set_ni;
      assign clr     = ~clr_buf;
      assign set     = ~set_buf;
    end else begin : g_dir
      assign clr = ~rst_ni;
      assign set = ~set_ni;
    end
  endgenerate

  for (genvar c = 0; c < NCOPY; c++) begin : g_cp
    tmr_copy_ff u_ff (
      .clk_i  (clk_i),
      .clr_i  (clr),
      .set_i  (set),
      .d_i    (d_i),
      .flip_i (flip_i[c]),
      .q_o    (cp[c])
    );
  end

  assign vote_o = vote3(cp);
  assign miss_o = mismatch3(cp);
endmodule

// File: rtl/tmr_shift_reg.sv
module tmr_shift_reg #(
  parameter int unsigned LEN      = 100,
  parameter bit          CTRL_BUF = 1'b1,
  localparam int unsigned NCOPY   = 3,
  localparam int unsigned FW      = LEN * NCOPY
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_ni,
  input  logic          din_i,
  input  logic [FW-1:0] flip_i,
  output logic          dout_o,
  output logic          err_o
);
  logic [LEN-1:0] vote;
  logic [LEN-1:0] miss;

  for (genvar s = 0; s < LEN; s++) begin : g_stg
    logic d;
    if (s == 0) begin : g_head
      assign d = din_i;
    end else begin : g_body
      assign d = vote[s-1];
    end
    tmr_stage #(.NCOPY(NCOPY), .CTRL_BUF(CTRL_BUF)) u_stg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_ni (set_ni),
      .d_i    (d),
      .flip_i (flip_i[NCOPY*s +: NCOPY]),
      .vote_o (vote[s]),
      .miss_o (miss[s])
    );
  end

  assign dout_o = vote[LEN-1];
  assign err_o  = |miss;
endmodule

// File: rtl/tmr_shift_reg_chk.sv
module tmr_shift_reg_chk #(
  parameter int unsigned LEN = 100
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             set_ni,
  input logic [3*LEN-1:0] flip_i,
  input logic [LEN-1:0]   vote_i,
  input logic             dout_o,
  input logic             err_o
);
  a_r3_flip_raises_err: assert property (@(posedge clk_i) disable iff (!rst_ni || !set_ni)
    (flip_i != '0) |=> err_o);

  a_r4_err_clears: assert property (@(posedge clk_i) disable iff (!rst_ni || !set_ni)
    (flip_i == '0) |=> !err_o);

  a_r2_single_keeps_dout: assert property (@(posedge clk_i) disable iff (!rst_ni || !set_ni)
    ($countones(flip_i[3*LEN-1 -: 3]) < 2) |=> (dout_o == $past(vote_i[LEN-2])));

  a_r5_double_inverts: assert property (@(posedge clk_i) disable iff (!rst_ni || !set_ni)
    ($countones(flip_i[3*LEN-1 -: 3]) == 2) |=> (dout_o != $past(vote_i[LEN-2])));

  a_r7_clear_state: assert property (@(posedge clk_i)
    !rst_ni |-> (!dout_o && !err_o));

  a_r8_preset_state: assert property (@(posedge clk_i)
    (rst_ni && !set_ni) |-> (dout_o && !err_o));
endmodule

bind tmr_shift_reg tmr_shift_reg_chk #(.LEN(LEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .set_ni (set_ni),
  .flip_i (flip_i),
  .vote_i (vote),
  .dout_o (dout_o),
  .err_o  (err_o)
);

// File: tb/tmr_shift_reg_tb_top.sv
module tmr_shift_reg_tb_top;
  localparam int unsigned LEN   = 100;
  localparam int unsigned LEN_B = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b1, set_ni = 1'b1, din = 1'b0;
  logic [3*LEN-1:0]   flip = '0;
  logic [3*LEN_B-1:0] flip_b = '0;
  logic dout, err, dout_b, err_b;

  int checks = 0, errors = 0;
  bit done = 0;
  bit q[$];
  bit qb[$];
  bit prev_flip = 0, prev_inv = 0;

  always #2ns clk = ~clk;

  tmr_shift_reg #(.LEN(LEN), .CTRL_BUF(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .set_ni(set_ni), .din_i(din),
    .flip_i(flip), .dout_o(dout), .err_o(err));

  tmr_shift_reg #(.LEN(LEN_B), .CTRL_BUF(1'b0)) dut_b (
    .clk_i(clk), .rst_ni(rst_ni), .set_ni(set_ni), .din_i(din),
    .flip_i(flip_b), .dout_o(dout_b), .err_o(err_b));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: monitor the previous edge, then drive and push the next item
  task automatic step(input bit b, input int stg, input int ncp);
    bit e;
    @(negedge clk);
    chk(prev_flip ? "R3" : "R4_R1", err, prev_flip);
    if (q.size() == LEN) begin
      e = q.pop_front();
      chk(prev_inv ? "R5" : "R6_R2", dout, prev_inv ? ~e : e);
    end
    if (qb.size() == LEN_B) begin
      e = qb.pop_front();
      chk("R10", dout_b, e);
    end
    chk("R10_R1", err_b, 1'b0);
    din = b;
    flip = '0;
    for (int c = 0; c < ncp; c++) flip[3*stg+c] = 1'b1;
    prev_flip = (ncp > 0);
    prev_inv  = (ncp >= 2) && (stg == LEN-1);
    q.push_back(b);
    qb.push_back(b);
  endtask

  task automatic flush_sb();
    q.delete(); qb.delete();
    prev_flip = 0; prev_inv = 0;
  endtask

  initial begin
    #1ns rst_ni = 1'b0;
    @(negedge clk);
    chk("R7", dout, 1'b0); chk("R7", err, 1'b0); chk("R7_R10", dout_b, 1'b0);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk) set_ni = 1'b0;
    #1ns;
    chk("R8", dout, 1'b1); chk("R8", err, 1'b0); chk("R8_R10", dout_b, 1'b1);
    @(negedge clk) rst_ni = 1'b0;
    #1ns;
    chk("R9", dout, 1'b0); chk("R9_R10", dout_b, 1'b0); chk("R9", err, 1'b0);
    @(negedge clk) set_ni = 1'b1;
    @(negedge clk) rst_ni = 1'b1;
    flush_sb();
    // R6 all-zeros pattern
    for (int i = 0; i < 2*LEN; i++) step(1'b0, 0, 0);
    // R6 checkerboard pattern
    for (int i = 0; i < 3*LEN; i++) step(i[0], 0, 0);
    // R2/R3/R4 single flips at first, middle, last stage
    step(1'b1, 0, 1);      step(1'b0, 0, 0);
    step(1'b1, LEN/2, 1);  step(1'b0, 0, 0);
    step(1'b1, LEN-1, 1);  step(1'b0, 0, 0);
    for (int i = 0; i < 4; i++) step(i[0], 0, 0);
    // R5 double flip in last stage inverts dout for one cycle
    step(1'b1, LEN-1, 2);  step(1'b0, 0, 0);
    step(1'b1, 0, 0);
    // double flip mid-stage: error seen, corrupted bit not compared later
    step(1'b0, LEN/2, 2);
    step(1'b1, 0, 0);
    flush_sb();
    for (int i = 0; i < LEN + 8; i++) step(~i[0], 0, 0);
    step(1'b0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule